// File: doc/BRIEF.md
# Temperature-Aware DRAM Refresh Scheduler

This block sits beside a DDR2 command sequencer and decides when an auto-refresh must go out. A down-counter measures the average refresh period in clock cycles. Each expiry adds one owed refresh to a debt counter. While refreshes are owed, the block raises a request toward the sequencer. The request is held back until the sequencer reports that every bank is precharged and no earlier refresh is still settling. A grant in the same cycle as the request issues one refresh and pays one unit of debt. The debt may grow to a configurable ceiling, which lets the sequencer postpone refreshes during bursts of traffic. At the ceiling the request is flagged urgent.

A thermal input marks a case temperature above the normal band. While it is set, the period loaded at each interval boundary is half the normal one. The input is sampled only at reload, so a change never shortens or stretches an interval already running, and owed refreshes are kept.

The block also owns the clock-enable line for self-refresh. An entry pulse drops the clock enable when the banks are idle, clears the debt and freezes the timer. An exit pulse raises it again, but only after the line has held its level for the minimum pulse width. After exit, two separate windows block commands: one for non-read commands (activate, refresh), and a longer one for reads.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, cke_o is 1 and ref_req_o, ref_urgent_o, block_act_o and block_rd_o are 0, with debt_o equal to 0.
- R2: With hot_i low, debt_o rises by one exactly TREFI_CYC cycles after reset is released, and again every TREFI_CYC cycles after that.
- R3: An interval loaded while hot_i is 1 lasts TREFI_CYC/2 cycles. hot_i is sampled only when an interval is reloaded, so a change in mid-interval leaves the running interval and the debt unchanged.
- R4: debt_o saturates at DEBT_MAX. ref_urgent_o is 1 exactly while debt_o equals DEBT_MAX.
- R5: ref_req_o is 1 only while debt_o is nonzero, banks_idle_i is 1, cke_o is 1 and no post-refresh or post-exit non-read window is open. A grant without a request changes nothing.
- R6: A cycle with ref_req_o and ref_grant_i both at 1 issues one refresh. debt_o drops by one on the next cycle, and block_act_o is 1 for exactly TRFC_CYC cycles, during which ref_req_o stays 0.
- R7: An sr_enter_i pulse is taken only when all of these hold: the block is running, banks_idle_i is 1, no refresh is issued in that cycle, no non-read window is open, and cke_o has been high for at least CKE_MIN_CYC cycles. When taken, cke_o is 0 on the next cycle, debt_o is cleared, both block outputs are 1 and the interval timer is frozen.
- R8: An sr_exit_i pulse is ignored until cke_o has been low for CKE_MIN_CYC cycles.
- R9: A taken exit sets cke_o to 1. block_act_o then stays 1 for TXSNR_CYC cycles and block_rd_o for TXSRD_CYC cycles, and the next debt increment comes a full interval after the exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hot_i | input | 1 | Case temperature above the normal band |
| banks_idle_i | input | 1 | All banks precharged and idle |
| ref_grant_i | input | 1 | Sequencer accepts the refresh request this cycle |
| sr_enter_i | input | 1 | Request to enter self-refresh |
| sr_exit_i | input | 1 | Request to leave self-refresh |
| ref_req_o | output | 1 | Refresh wanted now |
| ref_urgent_o | output | 1 | Debt at its ceiling |
| cke_o | output | 1 | Clock enable to the DRAM |
| block_act_o | output | 1 | Activate and refresh commands forbidden |
| block_rd_o | output | 1 | Read commands forbidden |
| debt_o | output | DEBT_W | Refreshes owed |

## Verification
The bench builds the block with these values: a 40-cycle interval, a debt ceiling of 4, a 5-cycle refresh window, 7 and 12 cycles for the two exit windows, and a 3-cycle CKE minimum. With these, saturation, the halved hot interval and a change of hot_i in mid-interval all happen within a few hundred cycles. The short windows let each one be sampled in its last blocked cycle and in its first free cycle. The self-refresh test checks three things: the exit is refused before the CKE minimum is met, the debt stays at zero during a stay longer than one interval, and the timer restarts from a full interval after exit.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;

   typedef enum logic {
      PWR_RUN  = 1'b0,
      PWR_SELF = 1'b1
   } pwr_state_e;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
   parameter int unsigned TREFI_CYC = 1950,
   parameter bit          HOT_HALVE = 1'b1,
   localparam int unsigned W        = $clog2(TREFI_CYC)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic hot_i,
   output logic tick_o
);

   localparam logic [W-1:0] FULL_M1 = W'(TREFI_CYC - 1);
   localparam logic [W-1:0] HALF_M1 = W'(TREFI_CYC / 2 - 1);

   logic [W-1:0] cnt_q;
   logic [W-1:0] reload;

   initial begin
      assert (TREFI_CYC >= 4) else $error("interval too short");
   end

   generate
      if (HOT_HALVE) begin : g_thermal
         assign reload = hot_i ? HALF_M1 : FULL_M1;
      end else begin : g_fixed
         assign reload = FULL_M1;
      end
   endgenerate

   assign tick_o = run_i && (cnt_q == '0);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= FULL_M1;
      end else if (!run_i || cnt_q == '0) begin
         cnt_q <= reload;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // two expiries can never be adjacent
   assert_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);

endmodule

// File: rtl/ref_debt_ctr.sv
module ref_debt_ctr #(
   parameter int unsigned DEBT_MAX = 8,
   localparam int unsigned W       = ref_sched_pkg::cnt_width(DEBT_MAX)
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         inc_i,
   input  logic         dec_i,
   input  logic         clr_i,
   output logic [W-1:0] debt_o,
   output logic         urgent_o
);

   localparam logic [W-1:0] CAP = W'(DEBT_MAX);

   logic [W-1:0] debt_q;
   logic [W-1:0] debt_d;

   initial begin
      assert (DEBT_MAX >= 1) else $error("debt ceiling must be positive");
   end

   always_comb begin
      debt_d = debt_q;
      if (clr_i) begin
         debt_d = '0;
      end else if (inc_i && !dec_i) begin
         if (debt_q != CAP) debt_d = debt_q + 1'b1;
      end else if (dec_i && !inc_i) begin
         if (debt_q != '0) debt_d = debt_q - 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) debt_q <= '0;
      else         debt_q <= debt_d;
   end

   assign debt_o   = debt_q;
   assign urgent_o = (debt_q == CAP);

   assert_debt_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      debt_q <= CAP);

endmodule

// File: rtl/ref_hold_window.sv
module ref_hold_window #(
   parameter int unsigned LEN = 32,
   localparam int unsigned W  = ref_sched_pkg::cnt_width(LEN)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   output logic busy_o
);

   logic [W-1:0] cnt_q;

   initial begin
      assert (LEN >= 1) else $error("window length must be positive");
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= W'(LEN);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = (cnt_q != '0);

   assert_window_arm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> busy_o);

endmodule

// File: rtl/ref_pwr_fsm.sv
module ref_pwr_fsm #(
   parameter int unsigned CKE_MIN_CYC = 3,
   localparam int unsigned W          = ref_sched_pkg::cnt_width(CKE_MIN_CYC)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic enter_i,
   input  logic exit_i,
   input  logic enter_ok_i,
   output logic cke_o,
   output logic self_o,
   output logic enter_fire_o,
   output logic exit_fire_o
);
   import ref_sched_pkg::*;

   localparam logic [W-1:0] MINW = W'(CKE_MIN_CYC);

   pwr_state_e   state_q;
   logic [W-1:0] hold_q;
   logic         hold_met;

   initial begin
      assert (CKE_MIN_CYC >= 1) else $error("CKE minimum must be positive");
   end

   assign hold_met     = (hold_q >= MINW);
   assign enter_fire_o = (state_q == PWR_RUN)  && enter_i && enter_ok_i && hold_met;
   assign exit_fire_o  = (state_q == PWR_SELF) && exit_i && hold_met;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= PWR_RUN;
         hold_q  <= MINW;
      end else if (enter_fire_o) begin
         state_q <= PWR_SELF;
         hold_q  <= W'(1);
      end else if (exit_fire_o) begin
         state_q <= PWR_RUN;
         hold_q  <= W'(1);
      end else if (!hold_met) begin
         hold_q  <= hold_q + 1'b1;
      end
   end

   assign self_o = (state_q == PWR_SELF);
   assign cke_o  = (state_q == PWR_RUN);

   // independent level-age counter for the pulse-width check
   logic         chk_cke_q;
   logic [W-1:0] chk_age_q;
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         chk_cke_q <= 1'b1;
         chk_age_q <= MINW;
      end else begin
         chk_cke_q <= cke_o;
         if (cke_o != chk_cke_q)  chk_age_q <= W'(1);
         else if (chk_age_q < MINW) chk_age_q <= chk_age_q + 1'b1;
      end
   end

   assert_cke_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cke_o != chk_cke_q) |-> (chk_age_q >= MINW));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
   parameter int unsigned TREFI_CYC   = 1950,
   parameter int unsigned TRFC_CYC    = 32,
   parameter int unsigned TXSNR_CYC   = 35,
   parameter int unsigned TXSRD_CYC   = 200,
   parameter int unsigned CKE_MIN_CYC = 3,
   parameter int unsigned DEBT_MAX    = 8,
   localparam int unsigned DEBT_W     = ref_sched_pkg::cnt_width(DEBT_MAX)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              hot_i,
   input  logic              banks_idle_i,
   input  logic              ref_grant_i,
   input  logic              sr_enter_i,
   input  logic              sr_exit_i,
   output logic              ref_req_o,
   output logic              ref_urgent_o,
   output logic              cke_o,
   output logic              block_act_o,
   output logic              block_rd_o,
   output logic [DEBT_W-1:0] debt_o
);

   logic tick, fire, enter_ok, enter_fire, exit_fire, self_st;
   logic rfc_busy, xsnr_busy, xsrd_busy;

   initial begin
      assert (TXSRD_CYC >= TXSNR_CYC) else $error("read exit window shorter than non-read");
   end

   ref_interval_timer #(.TREFI_CYC(TREFI_CYC), .HOT_HALVE(1'b1)) u_timer (
      .clk_i, .rst_ni, .run_i(!self_st), .hot_i, .tick_o(tick));

   assign ref_req_o = !self_st && (debt_o != '0) && banks_idle_i && !rfc_busy && !xsnr_busy;
   assign fire      = ref_req_o && ref_grant_i;
   assign enter_ok  = banks_idle_i && !rfc_busy && !xsnr_busy && !fire;

   ref_debt_ctr #(.DEBT_MAX(DEBT_MAX)) u_debt (
      .clk_i, .rst_ni, .inc_i(tick), .dec_i(fire), .clr_i(enter_fire),
      .debt_o, .urgent_o(ref_urgent_o));

   ref_pwr_fsm #(.CKE_MIN_CYC(CKE_MIN_CYC)) u_pwr (
      .clk_i, .rst_ni, .enter_i(sr_enter_i), .exit_i(sr_exit_i), .enter_ok_i(enter_ok),
      .cke_o, .self_o(self_st), .enter_fire_o(enter_fire), .exit_fire_o(exit_fire));

   ref_hold_window #(.LEN(TRFC_CYC)) u_rfc_win (
      .clk_i, .rst_ni, .load_i(fire), .busy_o(rfc_busy));

   ref_hold_window #(.LEN(TXSNR_CYC)) u_xsnr_win (
      .clk_i, .rst_ni, .load_i(exit_fire), .busy_o(xsnr_busy));

   ref_hold_window #(.LEN(TXSRD_CYC)) u_xsrd_win (
      .clk_i, .rst_ni, .load_i(exit_fire), .busy_o(xsrd_busy));

   assign block_act_o = self_st || rfc_busy || xsnr_busy;
   assign block_rd_o  = self_st || xsrd_busy;

   assert_grant_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ref_req_o && ref_grant_i) |=> (block_act_o && !ref_req_o));

   assert_req_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_req_o |-> (banks_idle_i && cke_o && debt_o != '0));

   assert_sr_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cke_o) |-> (debt_o == '0 && block_act_o && block_rd_o));

   assert_exit_windows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cke_o) |-> (block_act_o && block_rd_o));

endmodule

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;

   localparam int unsigned P_TREFI = 40;
   localparam int unsigned P_TRFC  = 5;
   localparam int unsigned P_XSNR  = 7;
   localparam int unsigned P_XSRD  = 12;
   localparam int unsigned P_CKE   = 3;
   localparam int unsigned P_DEBT  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hot = 1'b0, idle = 1'b0, grant = 1'b0, sr_in = 1'b0, sr_out = 1'b0;
   logic req, urg, cke, blk, rblk;
   logic [2:0] debt;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   dram_refresh_sched #(
      .TREFI_CYC(P_TREFI), .TRFC_CYC(P_TRFC), .TXSNR_CYC(P_XSNR),
      .TXSRD_CYC(P_XSRD), .CKE_MIN_CYC(P_CKE), .DEBT_MAX(P_DEBT)
   ) u_dram_refresh_sched (
      .clk_i(clk), .rst_ni(rst_n), .hot_i(hot), .banks_idle_i(idle),
      .ref_grant_i(grant), .sr_enter_i(sr_in), .sr_exit_i(sr_out),
      .ref_req_o(req), .ref_urgent_o(urg), .cke_o(cke),
      .block_act_o(blk), .block_rd_o(rblk), .debt_o(debt));

   // {hot, idle, grant, edges[7:0], debt[3:0], req, urg, blk, req_id[3:0]}
   localparam logic [21:0] VEC [17] = '{
      {1'b0,1'b0,1'b0, 8'd39, 4'd0, 1'b0,1'b0,1'b0, 4'd2},  // R2 one short of the interval
      {1'b0,1'b0,1'b0, 8'd1,  4'd1, 1'b0,1'b0,1'b0, 4'd2},  // R2 first expiry
      {1'b1,1'b0,1'b0, 8'd39, 4'd1, 1'b0,1'b0,1'b0, 4'd3},  // R3 hot mid-interval, no effect
      {1'b1,1'b0,1'b0, 8'd1,  4'd2, 1'b0,1'b0,1'b0, 4'd3},  // R3 expiry at full length
      {1'b0,1'b0,1'b0, 8'd19, 4'd2, 1'b0,1'b0,1'b0, 4'd3},  // R3 halved interval running
      {1'b0,1'b0,1'b0, 8'd1,  4'd3, 1'b0,1'b0,1'b0, 4'd3},  // R3 halved expiry
      {1'b0,1'b1,1'b0, 8'd1,  4'd3, 1'b1,1'b0,1'b0, 4'd5},  // R5 idle raises request
      {1'b0,1'b0,1'b0, 8'd39, 4'd4, 1'b0,1'b1,1'b0, 4'd4},  // R4 ceiling reached
      {1'b0,1'b0,1'b0, 8'd40, 4'd4, 1'b0,1'b1,1'b0, 4'd4},  // R4 saturation
      {1'b0,1'b1,1'b1, 8'd1,  4'd3, 1'b0,1'b0,1'b1, 4'd6},  // R6 refresh issued
      {1'b0,1'b1,1'b0, 8'd4,  4'd3, 1'b0,1'b0,1'b1, 4'd6},  // R6 last blocked cycle
      {1'b0,1'b1,1'b0, 8'd1,  4'd3, 1'b1,1'b0,1'b0, 4'd6},  // R6 window over
      {1'b0,1'b1,1'b1, 8'd3,  4'd2, 1'b0,1'b0,1'b1, 4'd6},  // R6 second refresh
      {1'b0,1'b1,1'b1, 8'd3,  4'd2, 1'b1,1'b0,1'b0, 4'd6},  // R6 grant inside window ignored
      {1'b0,1'b0,1'b1, 8'd5,  4'd2, 1'b0,1'b0,1'b0, 4'd5},  // R5 grant while busy banks
      {1'b0,1'b0,1'b0, 8'd23, 4'd3, 1'b0,1'b0,1'b0, 4'd2},  // R2 periodic expiry
      {1'b0,1'b1,1'b1, 8'd1,  4'd2, 1'b0,1'b0,1'b1, 4'd6}   // R6 refresh again
   };

   task automatic check(input string rid, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", rid, what, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   task automatic check_reset_state(input string rid);
      check(rid, "cke", int'(cke), 1);
      check(rid, "req", int'(req), 0);
      check(rid, "urgent", int'(urg), 0);
      check(rid, "debt", int'(debt), 0);
      check(rid, "block_act", int'(blk), 0);
      check(rid, "block_rd", int'(rblk), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog (all requirements) actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_reset_state("R1");
      rst_n = 1'b1;

      for (int i = 0; i < 17; i++) begin
         logic [21:0] e;
         string rid;
         e = VEC[i];
         rid = $sformatf("R%0d", e[3:0]);
         hot = e[21]; idle = e[20]; grant = e[19];
         edges(int'(e[18:11]));
         check(rid, "debt", int'(debt), int'(e[10:7]));
         check(rid, "req", int'(req), int'(e[6]));
         check(rid, "urgent", int'(urg), int'(e[5]));
         check(rid, "block_act", int'(blk), int'(e[4]));
      end

      // self-refresh sequence
      idle = 1'b1; grant = 1'b0;
      edges(6);
      check("R5", "req before entry", int'(req), 1);
      sr_in = 1'b1;
      edges(1);
      sr_in = 1'b0;
      check("R7", "cke after entry", int'(cke), 0);
      check("R7", "debt cleared", int'(debt), 0);
      check("R7", "req in self", int'(req), 0);
      check("R7", "block_act in self", int'(blk), 1);
      check("R7", "block_rd in self", int'(rblk), 1);
      sr_out = 1'b1;
      edges(1);
      sr_out = 1'b0;
      check("R8", "early exit ignored", int'(cke), 0);
      edges(45);
      check("R7", "timer frozen debt", int'(debt), 0);
      check("R7", "still in self", int'(cke), 0);
      sr_out = 1'b1;
      edges(1);
      sr_out = 1'b0;
      check("R9", "cke after exit", int'(cke), 1);
      check("R9", "block_act after exit", int'(blk), 1);
      check("R9", "block_rd after exit", int'(rblk), 1);
      edges(P_XSNR - 1);
      check("R9", "non-read window last", int'(blk), 1);
      edges(1);
      check("R9", "non-read window end", int'(blk), 0);
      check("R9", "read window open", int'(rblk), 1);
      edges(P_XSRD - P_XSNR - 1);
      check("R9", "read window last", int'(rblk), 1);
      edges(1);
      check("R9", "read window end", int'(rblk), 0);
      edges(P_TREFI - P_XSRD - 1);
      check("R9", "full interval pending", int'(debt), 0);
      edges(1);
      check("R9", "full interval expiry", int'(debt), 1);

      // entry refused while a refresh window is open
      grant = 1'b1;
      edges(1);
      grant = 1'b0;
      check("R6", "debt paid", int'(debt), 0);
      sr_in = 1'b1;
      edges(1);
      sr_in = 1'b0;
      check("R7", "entry in window refused", int'(cke), 1);

      // reset in mid-run
      rst_n = 1'b0;
      edges(2);
      check_reset_state("R1");
      rst_n = 1'b1;
      edges(1);

      finish_run();
   end

endmodule